// File: doc/BRIEF.md
# Prioritised Locality Access Arbiter

This block decides which of five localities (0 to 4) owns a shared security coprocessor at any time. A higher number means a higher priority. Each locality talks to the arbiter through a 4-bit control write. The write is tagged with the locality number. Through it a locality can ask for access, give up ownership, preempt a lower-priority owner, or set the established flag. A separate hash-end pulse clears that flag.

The block reports a shared 8-bit state word plus two per-locality vectors. The state word carries a valid flag, an assigned flag, the active locality number and the established flag. The two vectors are a granted flag and a sticky "been preempted" flag for each locality. Requests that arrive while the coprocessor is owned are held as pending. They are granted highest-number-first as soon as the owner lets go.

Top module: `loc_access_arbiter`

## Requirements
- R1: While rst_ni is low, state_o reads 8'h01 (valid 0, nothing assigned, established 1), and granted_o and seized_o are all zero.
- R2: A write with wr_ctrl_i bit 0 (request) from a locality that is not the owner marks that locality pending at that edge. When nothing is assigned, the pending locality is granted at the following edge.
- R3: When nothing is assigned and several localities are pending, the highest-numbered pending locality is granted at the next edge. The other pending requests are kept.
- R4: A write with bit 1 (relinquish) from the owner releases ownership at that edge, and the remaining pending requests are arbitrated at the next edge. A relinquish write from a non-owner withdraws that locality's own pending request.
- R5: A write with bit 2 (seize) from a locality numbered above the owner makes the writer the owner at that edge, and sets the previous owner's seized_o bit. A seize while nothing is assigned grants the writer at that edge, ahead of any pending arbitration.
- R6: A seize write from a locality numbered at or below the owner's number leaves the ownership unchanged.
- R7: A locality's seized_o bit clears when that locality writes a request or is granted. The owner's seized_o bit is never 1.
- R8: A write with bit 3 (reset establishment) sets the established flag only when it comes from locality 3 or 4. The same write from localities 0 to 2 leaves the flag unchanged.
- R9: A hash_end_i pulse clears the established flag at that edge. It wins over an accepted establishment write in the same cycle.
- R10: state_o bit 7 is the valid flag, 1 from the first edge after reset. Bits 6:5 are 0. Bits 4:2 are the active locality in binary, 0 when none is assigned. Bit 1 is the assigned flag. Bit 0 is the established flag. granted_o is one-hot on the active locality, and zero when nothing is assigned.
- R11: Writes tagged with locality 5 to 7 have no effect. A request write from the current owner is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Control write strobe |
| wr_loc_i | input | 3 | Locality issuing the write |
| wr_ctrl_i | input | 4 | Control bits: 0 request, 1 relinquish, 2 seize, 3 reset establishment |
| hash_end_i | input | 1 | Hash-end event pulse |
| state_o | output | 8 | Shared state word |
| granted_o | output | 5 | Per-locality granted flag |
| seized_o | output | 5 | Per-locality been-seized flag |

## Verification
The bench targets several corner cases, each with the failure it would expose:
- Arbitration among several waiting requests: a low-first or first-come arbiter would hand ownership to the wrong locality.
- A relinquish that must leave other pending requests in place: a design that cleared every request on release would leave the coprocessor unowned.
- Seizes from equal or lower localities: a careless magnitude compare would let them steal ownership.
- The sticky preempted flag across re-request and re-grant: a design that forgot to clear it would show an owner marked as seized.
- Establishment writes from unprivileged localities and a hash-end pulse in the same cycle as an accepted write: these expose a wrong locality threshold or the wrong set/clear priority.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int NUM_LOC    = 5;
  localparam int LOC_W      = $clog2(NUM_LOC);
  localparam int CTRL_W     = 4;
  localparam int CTRL_REQ   = 0;
  localparam int CTRL_REL   = 1;
  localparam int CTRL_SEIZE = 2;
  localparam int CTRL_ESTAB = 3;
  typedef logic [LOC_W-1:0]   loc_t;
  typedef logic [NUM_LOC-1:0] loc_vec_t;
endpackage

// File: rtl/loc_arb_owner.sv
module loc_arb_owner
  import loc_arb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_ok_i,
  input  loc_t     wr_loc_i,
  input  logic     seize_i,
  input  logic     rel_i,
  input  loc_vec_t pend_i,
  output logic     assigned_o,
  output loc_t     active_o,
  output logic     grant_en_o,
  output loc_t     grant_loc_o,
  output logic     victim_en_o,
  output loc_t     victim_loc_o
);
  logic assigned_q, assigned_d;
  loc_t active_q, active_d, hi_loc;
  logic seize_ok;

  always_comb begin
    hi_loc = '0;
    for (int i = 0; i < NUM_LOC; i++)
      if (pend_i[i]) hi_loc = LOC_W'(i);
  end

  assign seize_ok = wr_ok_i && seize_i && (!assigned_q || wr_loc_i > active_q);

  always_comb begin
    assigned_d   = assigned_q;
    active_d     = active_q;
    grant_en_o   = 1'b0;
    grant_loc_o  = '0;
    victim_en_o  = 1'b0;
    victim_loc_o = active_q;
    if (seize_ok) begin
      victim_en_o = assigned_q;
      grant_en_o  = 1'b1;
      grant_loc_o = wr_loc_i;
      assigned_d  = 1'b1;
      active_d    = wr_loc_i;
    end else if (wr_ok_i && rel_i && assigned_q && wr_loc_i == active_q) begin
      assigned_d = 1'b0;
      active_d   = '0;
    end else if (!assigned_q && |pend_i) begin
      grant_en_o  = 1'b1;
      grant_loc_o = hi_loc;
      assigned_d  = 1'b1;
      active_d    = hi_loc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      assigned_q <= 1'b0;
      active_q   <= '0;
    end else begin
      assigned_q <= assigned_d;
      active_q   <= active_d;
    end
  end

  assign assigned_o = assigned_q;
  assign active_o   = active_q;
endmodule

// File: rtl/loc_arb_pending.sv
module loc_arb_pending
  import loc_arb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_ok_i,
  input  loc_t     wr_loc_i,
  input  logic     req_i,
  input  logic     rel_i,
  input  logic     assigned_i,
  input  loc_t     active_i,
  input  logic     grant_en_i,
  input  loc_t     grant_loc_i,
  input  logic     victim_en_i,
  input  loc_t     victim_loc_i,
  output loc_vec_t pend_o,
  output loc_vec_t seized_o
);
  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    logic own_wr, is_owner, set_req, clr_req, grant, victim;
    logic pend_q, seized_q;
    assign own_wr   = wr_ok_i && wr_loc_i == LOC_W'(i);
    assign is_owner = assigned_i && active_i == LOC_W'(i);
    assign set_req  = own_wr && req_i && !is_owner;
    assign clr_req  = own_wr && rel_i && !is_owner;
    assign grant    = grant_en_i && grant_loc_i == LOC_W'(i);
    assign victim   = victim_en_i && victim_loc_i == LOC_W'(i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q   <= 1'b0;
        seized_q <= 1'b0;
      end else begin
        if (grant || clr_req) pend_q <= 1'b0;
        else if (set_req)     pend_q <= 1'b1;
        if (grant)            seized_q <= 1'b0;
        else if (victim)      seized_q <= 1'b1;
        else if (set_req)     seized_q <= 1'b0;
      end
    end
    assign pend_o[i]   = pend_q;
    assign seized_o[i] = seized_q;
  end
endmodule

// File: rtl/loc_arb_estab.sv
module loc_arb_estab
  import loc_arb_pkg::*;
#(
  parameter int MIN_LOC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_ok_i,
  input  loc_t wr_loc_i,
  input  logic estab_i,
  input  logic hash_end_i,
  output logic est_o
);
  logic est_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           est_q <= 1'b1;
    else if (hash_end_i)                                   est_q <= 1'b0;
    else if (wr_ok_i && estab_i && wr_loc_i >= LOC_W'(MIN_LOC)) est_q <= 1'b1;
  end
  assign est_o = est_q;
endmodule

// File: rtl/loc_access_arbiter.sv
module loc_access_arbiter
  import loc_arb_pkg::*;
#(
  parameter int ESTAB_MIN_LOC = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_valid_i,
  input  logic [LOC_W-1:0]     wr_loc_i,
  input  logic [CTRL_W-1:0]    wr_ctrl_i,
  input  logic                 hash_end_i,
  output logic [7:0]           state_o,
  output logic [NUM_LOC-1:0]   granted_o,
  output logic [NUM_LOC-1:0]   seized_o
);
  logic     wr_ok, assigned, grant_en, victim_en, est, valid_q;
  loc_t     active, grant_loc, victim_loc;
  loc_vec_t pend;

  assign wr_ok = wr_valid_i && wr_loc_i < LOC_W'(NUM_LOC);

  loc_arb_owner u_owner (
    .clk_i, .rst_ni,
    .wr_ok_i(wr_ok), .wr_loc_i,
    .seize_i(wr_ctrl_i[CTRL_SEIZE]), .rel_i(wr_ctrl_i[CTRL_REL]),
    .pend_i(pend),
    .assigned_o(assigned), .active_o(active),
    .grant_en_o(grant_en), .grant_loc_o(grant_loc),
    .victim_en_o(victim_en), .victim_loc_o(victim_loc)
  );

  loc_arb_pending u_pend (
    .clk_i, .rst_ni,
    .wr_ok_i(wr_ok), .wr_loc_i,
    .req_i(wr_ctrl_i[CTRL_REQ]), .rel_i(wr_ctrl_i[CTRL_REL]),
    .assigned_i(assigned), .active_i(active),
    .grant_en_i(grant_en), .grant_loc_i(grant_loc),
    .victim_en_i(victim_en), .victim_loc_i(victim_loc),
    .pend_o(pend), .seized_o
  );

  loc_arb_estab #(.MIN_LOC(ESTAB_MIN_LOC)) u_estab (
    .clk_i, .rst_ni,
    .wr_ok_i(wr_ok), .wr_loc_i,
    .estab_i(wr_ctrl_i[CTRL_ESTAB]), .hash_end_i,
    .est_o(est)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= 1'b1;
  end

  assign state_o = {valid_q, 2'b00, active, assigned, est};

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_gnt
    assign granted_o[i] = assigned && active == LOC_W'(i);
  end
endmodule

// File: rtl/loc_access_arbiter_chk.sv
module loc_access_arbiter_chk
  import loc_arb_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_valid_i,
  input logic [LOC_W-1:0]   wr_loc_i,
  input logic [CTRL_W-1:0]  wr_ctrl_i,
  input logic               hash_end_i,
  input logic [7:0]         state_o,
  input logic [NUM_LOC-1:0] granted_o,
  input logic [NUM_LOC-1:0] seized_o
);
  logic ok_wr;
  assign ok_wr = wr_valid_i && wr_loc_i < LOC_W'(NUM_LOC);

  p_seize_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_wr && wr_ctrl_i[CTRL_SEIZE] && state_o[1] && wr_loc_i > state_o[4:2])
    |=> (state_o[1] && state_o[4:2] == $past(wr_loc_i)));

  p_seize_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_wr && wr_ctrl_i[CTRL_SEIZE] && !wr_ctrl_i[CTRL_REL] && state_o[1]
     && wr_loc_i <= state_o[4:2])
    |=> (state_o[1] && state_o[4:2] == $past(state_o[4:2])));

  p_owner_clean_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (granted_o & seized_o) == '0);

  p_estab_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!state_o[0] && !(ok_wr && wr_ctrl_i[CTRL_ESTAB] && wr_loc_i >= 3)) |=> !state_o[0]);

  p_hash_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_end_i |=> !state_o[0]);

  p_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(granted_o));

  p_assigned_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o[1] == (|granted_o));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o[1] && !hash_end_i && !ok_wr) |=> $stable(state_o));
endmodule

bind loc_access_arbiter loc_access_arbiter_chk chk_i (.*);

// File: tb/loc_access_arbiter_tb_top.sv
module loc_access_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [2:0] wr_loc = '0;
  logic [3:0] wr_ctrl = '0;
  logic       hash_end = 1'b0;
  logic [7:0] state;
  logic [4:0] granted, seized;

  int checks = 0;
  int errors = 0;

  logic [4:0] m_pend = '0, m_seized = '0;
  logic       m_asg = 1'b0, m_est = 1'b1, m_valid = 1'b0;
  logic [2:0] m_act = '0;

  always #5 clk = ~clk;

  loc_access_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_loc_i(wr_loc),
    .wr_ctrl_i(wr_ctrl), .hash_end_i(hash_end),
    .state_o(state), .granted_o(granted), .seized_o(seized)
  );

  function automatic logic [7:0] exp_state();
    return {m_valid, 2'b00, m_asg ? m_act : 3'd0, m_asg, m_est};
  endfunction

  function automatic logic [4:0] exp_gnt();
    return m_asg ? (5'b1 << m_act) : 5'b0;
  endfunction

  task automatic model_edge(input logic v, input logic [2:0] loc,
                            input logic [3:0] c, input logic he);
    logic ok, seize_ok, g_en, own;
    logic [2:0] gl, hi;
    logic [4:0] np, ns;
    logic na, ne;
    logic [2:0] nact;
    ok = v && loc < 3'd5;
    own = m_asg && loc == m_act;
    seize_ok = ok && c[2] && (!m_asg || loc > m_act);
    np = m_pend; ns = m_seized; na = m_asg; nact = m_act; ne = m_est;
    g_en = 1'b0; gl = '0; hi = '0;
    for (int i = 0; i < 5; i++) if (m_pend[i]) hi = 3'(i);
    if (seize_ok) begin
      if (m_asg) ns[m_act] = 1'b1;
      na = 1'b1; nact = loc; g_en = 1'b1; gl = loc;
    end else if (ok && c[1] && own) begin
      na = 1'b0; nact = '0;
    end else if (!m_asg && m_pend != 0) begin
      na = 1'b1; nact = hi; g_en = 1'b1; gl = hi;
    end
    if (ok && c[0] && !own) begin np[loc] = 1'b1; ns[loc] = 1'b0; end
    if (ok && c[1] && !own) np[loc] = 1'b0;
    if (g_en) begin np[gl] = 1'b0; ns[gl] = 1'b0; end
    if (ok && c[3] && loc >= 3'd3) ne = 1'b1;
    if (he) ne = 1'b0;
    m_pend = np; m_seized = ns; m_asg = na; m_act = nact; m_est = ne; m_valid = 1'b1;
  endtask

  task automatic check8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check8(tag, "state_o", state, exp_state());
    check8(tag, "granted_o", {3'b0, granted}, {3'b0, exp_gnt()});
    check8(tag, "seized_o", {3'b0, seized}, {3'b0, m_seized});
  endtask

  task automatic step(input string tag, input logic v, input logic [2:0] loc,
                      input logic [3:0] c, input logic he);
    @(negedge clk);
    wr_valid = v; wr_loc = loc; wr_ctrl = c; hash_end = he;
    model_edge(v, loc, c, he);
    @(posedge clk);
    #1;
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 3'd0, 4'd0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
    idle("R10");                               // valid appears
    step("R2", 1'b1, 3'd1, 4'b0001, 1'b0);     // request from 1
    idle("R2");                                // granted next edge
    step("R11", 1'b1, 3'd1, 4'b0001, 1'b0);    // owner request ignored
    step("R3", 1'b1, 3'd0, 4'b0001, 1'b0);
    step("R3", 1'b1, 3'd2, 4'b0001, 1'b0);
    step("R4", 1'b1, 3'd1, 4'b0010, 1'b0);     // owner releases
    idle("R3");                                // highest pending (2) wins
    step("R4", 1'b1, 3'd0, 4'b0010, 1'b0);     // non-owner withdraws
    step("R4", 1'b1, 3'd2, 4'b0010, 1'b0);
    idle("R4");                                // nothing pending, stays free
    step("R5", 1'b1, 3'd0, 4'b0100, 1'b0);     // seize while free
    step("R5", 1'b1, 3'd3, 4'b0100, 1'b0);     // preempt 0
    step("R6", 1'b1, 3'd1, 4'b0100, 1'b0);
    step("R6", 1'b1, 3'd3, 4'b0100, 1'b0);
    step("R7", 1'b1, 3'd0, 4'b0001, 1'b0);     // re-request clears seized
    step("R9", 1'b0, 3'd0, 4'b0000, 1'b1);
    step("R8", 1'b1, 3'd2, 4'b1000, 1'b0);     // ignored
    step("R8", 1'b1, 3'd4, 4'b1000, 1'b0);     // accepted
    step("R9", 1'b1, 3'd3, 4'b1000, 1'b1);     // hash-end wins
    step("R11", 1'b1, 3'd6, 4'b1111, 1'b0);
    step("R11", 1'b1, 3'd7, 4'b0100, 1'b0);
    step("R10", 1'b1, 3'd4, 4'b0100, 1'b0);    // active = 4
    step("R7", 1'b1, 3'd4, 4'b0010, 1'b0);
    idle("R7");                                // pending 0 regranted
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] c;
      c = 4'($urandom);
      if ($urandom % 4 == 0) c[3] = 1'b0;
      step("R10", 1'($urandom), 3'($urandom), c, ($urandom % 12) == 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule